// File: doc/BRIEF.md
# Proximity Tag Frame Parser

This block sits behind a bit-recovery stage in a low-frequency proximity tag reader. It accepts one recovered bit per strobe and looks for a 64-bit tag frame in that stream. A frame starts with a run of nine 1 bits. Ten five-bit rows follow, each holding four data bits and one even-parity bit. Four column-parity bits and a stop bit close the frame. The parser checks parity in both directions over the 10 by 4 nibble grid. When every check passes, it publishes the 40-bit tag and its 8-bit version field together with a one-cycle valid strobe.

The control is a three-state machine. `ST_HUNT` counts consecutive ones. The transition *header found* moves to `ST_ROWS` on the ninth one. `ST_ROWS` steps through the bit position (0 to 4) and the row number (0 to 9). The transition *rows done* moves to `ST_COLS` after the parity bit of the tenth row. `ST_COLS` compares the four column bits and then the stop bit. The transition *frame end* returns to `ST_HUNT` on the stop bit, whatever the verdict. All outputs are registered and change on the clock edge that takes in the bit.

Top module: `tag_frame_parser`

## Requirements
- R1: While reset is asserted and after it is released, `tag_value`, `ver_value`, `row_par_err` and `tag_strobe` are all zero until a bit is accepted.
- R2: A header is nine accepted 1 bits in a row. An accepted 0 restarts the count. The bit accepted after the ninth 1 is the first data bit of row 0, even when that bit is itself a 1.
- R3: `row_par_err[r]` (bit 0 = first row after the header) goes to 1 on the edge that takes row r's parity bit, if the XOR of the row's four data bits and its parity bit is 1. All flags clear on the edge that completes the next header, and they hold their value until then.
- R4: On a valid frame, `tag_value` holds the 40 data bits in order of arrival, with the first bit received at bit 39 and the last data bit of row 9 at bit 0.
- R5: `ver_value` equals the data bits of rows 0 and 1, which is `tag_value[39:32]`. It is loaded at the same time as the tag.
- R6: Column bit k (k = 0..3, sent in that order after row 9) must equal the XOR of data bit k of all ten rows, where bit k is the (k+1)-th data bit of a row. Any mismatch suppresses the strobe.
- R7: The stop bit must be 0. A stop bit of 1 suppresses the strobe.
- R8: `tag_strobe` is high for exactly the one cycle after the edge that takes a good stop bit, and only when no row flag is set. `tag_value` and `ver_value` change only together with the strobe.
- R9: The bit accepted after any stop bit, whether the frame passed or failed, is handled by the header hunt.
- R10: Cycles with `bit_vld` low change nothing, whatever the value of `bit_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | Qualifies `bit_val` for this cycle |
| bit_val | input | 1 | Recovered bit |
| tag_value | output | 40 | Last accepted tag |
| ver_value | output | 8 | Version field of the last accepted tag |
| tag_strobe | output | 1 | One-cycle pulse when a new tag is loaded |
| row_par_err | output | 10 | Row parity failure flags for the current or last frame |

## Verification
The parity bit of the last row does two jobs on one edge. It records that row's flag, and it hands the machine to the column phase, whose column check must already include that row's data bits. The bench provokes this with frames that carry a row 9 parity fault and a column 3 fault, sent on back-to-back cycles and also with idle gaps between bits. A reference model built from queues judges every cycle: it recomputes both parity directions from the bits it has collected and expects the flag on bit 9, no strobe, and an unchanged tag.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_ROWS = 2'd1,
        ST_COLS = 2'd2
    } tfp_state_e;
endpackage

// File: rtl/tfp_hdr_detect.sv
module tfp_hdr_detect #(
    parameter int HDR_LEN = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_in,
    output logic found
);
    localparam int CW = $clog2(HDR_LEN + 1);
    logic [CW-1:0] run_q;

    assign found = en && bit_in && (run_q == CW'(HDR_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= '0;
        else if (en) begin
            if (!bit_in || found) run_q <= '0;
            else                  run_q <= run_q + 1'b1;
        end
    end

    // R2: the run of ones never passes the header length
    p_run_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < CW'(HDR_LEN));
    // R2: a zero restarts the count
    p_zero_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bit_in) |=> (run_q == '0));
endmodule

// File: rtl/tfp_parity_acc.sv
module tfp_parity_acc #(
    parameter int NIB_W = 4,
    parameter int IDX_W = $clog2(NIB_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             dat_en,
    input  logic             par_en,
    input  logic [IDX_W-1:0] col_idx,
    input  logic             bit_in,
    output logic             row_bad,
    output logic [NIB_W-1:0] col_acc
);
    logic row_acc;

    assign row_bad = par_en && (row_acc ^ bit_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                row_acc <= 1'b0;
        else if (clr || par_en)    row_acc <= 1'b0;
        else if (dat_en)           row_acc <= row_acc ^ bit_in;
    end

    for (genvar c = 0; c < NIB_W; c++) begin : g_col
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                col_acc[c] <= 1'b0;
            else if (clr)
                col_acc[c] <= 1'b0;
            else if (dat_en && (col_idx == IDX_W'(c)))
                col_acc[c] <= col_acc[c] ^ bit_in;
        end
    end

    // R3: a parity bit closes the row and restarts the row sum
    p_row_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (par_en && !clr) |=> (row_acc == 1'b0));
    // R6: column sums start from zero after a header
    p_col_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (col_acc == '0));
endmodule

// File: rtl/tag_frame_parser.sv
module tag_frame_parser #(
    parameter int HDR_LEN  = 9,
    parameter int NUM_ROWS = 10,
    parameter int NIB_W    = 4,
    parameter int VER_ROWS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bit_vld,
    input  logic                      bit_val,
    output logic [NUM_ROWS*NIB_W-1:0] tag_value,
    output logic [VER_ROWS*NIB_W-1:0] ver_value,
    output logic                      tag_strobe,
    output logic [NUM_ROWS-1:0]       row_par_err
);
    import tfp_pkg::*;

    localparam int TAG_W = NUM_ROWS * NIB_W;
    localparam int VER_W = VER_ROWS * NIB_W;
    localparam int POS_W = $clog2(NIB_W + 1);
    localparam int ROW_W = $clog2(NUM_ROWS);
    localparam int SEL_W = (NIB_W > 1) ? $clog2(NIB_W) : 1;

    tfp_state_e       state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic [TAG_W-1:0] shreg;
    logic             col_fail;
    logic             hdr_found, row_bad;
    logic [NIB_W-1:0] col_acc;

    wire in_rows  = bit_vld && (state_q == ST_ROWS);
    wire in_cols  = bit_vld && (state_q == ST_COLS);
    wire last_pos = (pos_q == POS_W'(NIB_W));
    wire dat_en   = in_rows && !last_pos;
    wire par_en   = in_rows && last_pos;
    wire col_chk  = in_cols && !last_pos;
    wire stop_now = in_cols && last_pos;
    wire col_sel  = col_acc[pos_q[SEL_W-1:0]];

    tfp_hdr_detect #(.HDR_LEN(HDR_LEN)) u_hdr (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (bit_vld && (state_q == ST_HUNT)),
        .bit_in (bit_val),
        .found  (hdr_found)
    );

    tfp_parity_acc #(.NIB_W(NIB_W), .IDX_W(POS_W)) u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hdr_found),
        .dat_en  (dat_en),
        .par_en  (par_en),
        .col_idx (pos_q),
        .bit_in  (bit_val),
        .row_bad (row_bad),
        .col_acc (col_acc)
    );

    // next state
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        row_d   = row_q;
        if (bit_vld) begin
            unique case (state_q)
                ST_HUNT: if (hdr_found) begin
                    state_d = ST_ROWS;
                    pos_d   = '0;
                    row_d   = '0;
                end
                ST_ROWS: if (last_pos) begin
                    pos_d = '0;
                    if (row_q == ROW_W'(NUM_ROWS - 1)) begin
                        row_d   = '0;
                        state_d = ST_COLS;
                    end else begin
                        row_d = row_q + 1'b1;
                    end
                end else begin
                    pos_d = pos_q + 1'b1;
                end
                ST_COLS: if (last_pos) begin
                    pos_d   = '0;
                    state_d = ST_HUNT;
                end else begin
                    pos_d = pos_q + 1'b1;
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            row_q   <= row_d;
        end
    end

    // outputs and frame data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg       <= '0;
            col_fail    <= 1'b0;
            row_par_err <= '0;
            tag_value   <= '0;
            ver_value   <= '0;
            tag_strobe  <= 1'b0;
        end else begin
            tag_strobe <= 1'b0;
            if (hdr_found) begin
                row_par_err <= '0;
                col_fail    <= 1'b0;
            end
            if (dat_en)
                shreg <= {shreg[TAG_W-2:0], bit_val};
            if (row_bad)
                row_par_err[row_q] <= 1'b1;
            if (col_chk && (bit_val ^ col_sel))
                col_fail <= 1'b1;
            if (stop_now && !bit_val && !col_fail && (row_par_err == '0)) begin
                tag_strobe <= 1'b1;
                tag_value  <= shreg;
                ver_value  <= shreg[TAG_W-1 -: VER_W];
            end
        end
    end

    // R8: strobe lasts one cycle
    p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tag_strobe |=> !tag_strobe);
    // R8: tag holds between strobes
    p_tag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_strobe |-> ($stable(tag_value) && $stable(ver_value)));
    // R5: version field mirrors the top of the tag
    p_ver_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tag_strobe |-> (ver_value == tag_value[TAG_W-1 -: VER_W]));
    // R3: no strobe over a row fault
    p_strobe_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tag_strobe |-> (row_par_err == '0));
    // R2: rows start only after a header
    p_enter_rows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROWS && $past(state_q) == ST_HUNT) |-> $past(hdr_found));
    // R9: hunt resumes only after a stop bit
    p_back_hunt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && $past(state_q) == ST_COLS) |-> $past(stop_now));
    // R10: idle cycles leave the control state alone
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> ($stable(state_q) && $stable(pos_q) && $stable(row_q)));
endmodule

// File: tb/tag_frame_parser_bench.sv
module tag_frame_parser_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_vld = 1'b0;
    logic        bit_val = 1'b0;
    logic [39:0] tag_value;
    logic [7:0]  ver_value;
    logic        tag_strobe;
    logic [9:0]  row_par_err;

    always #5 clk = ~clk;

    tag_frame_parser u_tag_frame_parser (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_vld     (bit_vld),
        .bit_val     (bit_val),
        .tag_value   (tag_value),
        .ver_value   (ver_value),
        .tag_strobe  (tag_strobe),
        .row_par_err (row_par_err)
    );

    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;
    bit    gaps = 0;
    string phase = "R1";
    logic [7:0] lf = 8'hA5;

    // reference model
    int          run = 0;
    bit          in_frame = 0;
    bit          fq[$];
    logic [9:0]  e_row = '0;
    logic [39:0] e_tag = '0;
    logic [7:0]  e_ver = '0;
    logic        e_vld = 1'b0;

    function automatic void model_bit(bit b);
        if (!in_frame) begin
            if (b) begin
                run++;
                if (run == 9) begin
                    in_frame = 1; run = 0; fq.delete(); e_row = '0;
                end
            end else run = 0;
        end else begin
            int n;
            fq.push_back(b);
            n = fq.size();
            if (n <= 50 && n % 5 == 0) begin
                bit p = 0;
                for (int i = n - 5; i < n; i++) p ^= fq[i];
                if (p) e_row[n/5 - 1] = 1'b1;
            end
            if (n == 55) begin
                bit ok = (e_row == '0) && (fq[54] == 1'b0);
                for (int k = 0; k < 4; k++) begin
                    bit c = fq[50 + k];
                    for (int r = 0; r < 10; r++) c ^= fq[r*5 + k];
                    if (c) ok = 0;
                end
                if (ok) begin
                    logic [39:0] t = '0;
                    for (int r = 0; r < 10; r++)
                        for (int k = 0; k < 4; k++) t = {t[38:0], fq[r*5 + k]};
                    e_vld = 1'b1; e_tag = t; e_ver = t[39:32];
                end
                in_frame = 0;
            end
        end
    endfunction

    task automatic compare();
        n_cmp++;
        if (tag_strobe !== e_vld || tag_value !== e_tag || ver_value !== e_ver
            || row_par_err !== e_row) begin
            n_bad++;
            $display("FAIL [%s] strobe(R6 R7 R8) %b/%b tag(R4) %h/%h ver(R5) %h/%h rowerr(R3) %b/%b (actual/expected)",
                     phase, tag_strobe, e_vld, tag_value, e_tag, ver_value, e_ver,
                     row_par_err, e_row);
        end
    endtask

    task automatic tick(bit v, bit b);
        compare();
        bit_vld = v;
        bit_val = b;
        e_vld = 1'b0;
        if (v) model_bit(b);
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        @(negedge clk);
    endtask

    task automatic send(bit b);
        if (gaps && lf[0]) tick(1'b0, lf[1]);  // R10: idle with junk value
        tick(1'b1, b);
    endtask

    task automatic frame(logic [39:0] d, int bad_row, int bad_col, bit stop);
        for (int i = 0; i < 9; i++) send(1'b1);
        for (int r = 0; r < 10; r++) begin
            logic [3:0] nib = d[39 - 4*r -: 4];
            bit p = ^nib;
            for (int k = 0; k < 4; k++) send(nib[3 - k]);
            if (r == bad_row) p = ~p;
            send(p);
        end
        for (int k = 0; k < 4; k++) begin
            bit c = 0;
            for (int r = 0; r < 10; r++) c ^= d[39 - 4*r - k];
            if (k == bad_col) c = ~c;
            send(c);
        end
        send(stop);
    endtask

    initial begin
        @(negedge clk);
        phase = "R1"; compare(); @(negedge clk); compare();
        rst_n = 1'b1;
        tick(1'b0, 1'b0); tick(1'b0, 1'b1);

        phase = "R2 R4 R5 R8 valid";      frame(40'h12_3456_789A, -1, -1, 1'b0);
        tick(1'b0, 1'b0); tick(1'b0, 1'b0);
        phase = "R3 R6 row9+col3 fault";  frame(40'hC0_FFEE_0135, 9, 3, 1'b0);
        phase = "R3 row0 fault";          frame(40'h5A_0000_FFFF, 0, -1, 1'b0);
        phase = "R9 after failure";       frame(40'hAB_CDEF_0123, -1, -1, 1'b0);
        phase = "R6 col0 fault";          frame(40'h77_1234_4321, -1, 0, 1'b0);
        phase = "R7 stop one";            frame(40'h99_8877_6655, -1, -1, 1'b1);
        phase = "R2 broken run";
        for (int i = 0; i < 8; i++) send(1'b1);
        send(1'b0);
        frame(40'h01_0203_0405, -1, -1, 1'b0);
        phase = "R2 long run";
        for (int i = 0; i < 3; i++) send(1'b1);
        frame(40'hFF_FFFF_FFFF, -1, -1, 1'b0);
        for (int i = 0; i < 70; i++) send(1'b0);
        phase = "R10 gaps";
        gaps = 1;
        frame(40'h3C_5A69_96A5, -1, -1, 1'b0);
        frame(40'hE1_D2C3_B4A5, 9, 3, 1'b0);
        gaps = 0;
        phase = "R9 back to back";
        frame(40'h00_0000_0001, -1, -1, 1'b0);
        frame(40'hFF_FFFF_FFFF, -1, -1, 1'b0);
        for (int i = 0; i < 4; i++) tick(1'b0, i[0]);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL [watchdog] run did not finish (actual hung / expected done)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule